// File: doc/BRIEF.md
# Slave Serial Audio Port

This block is the serial side of a stereo audio converter that always runs as a bus slave. An external master drives the bit clock and the left/right select line. The block never drives either one. On each rising bit-clock edge the port takes one serial input bit and builds a left and a right sample word from them. On each falling edge it puts the next bit of its own left or right transmit word on the serial output. Three framings are supported: I2S, MSB-justified and LSB-justified. The sample width can be 16, 18, 20 or 24 bits. Both format and width are static inputs that are changed only while the block is held in reset.

The serial inputs are oversampled by a free-running system clock that is locked to the audio timing. Each bit-clock phase must last at least `SYNC_STAGES + 3` system clock cycles. The serial lines pass through synchronizer stages of equal depth, so the select and data lines keep their alignment to the bit clock. Edges are then detected on the system clock. One channel may span up to 64 bit-clock slots, which is 128 per frame. A single-cycle strobe marks each completed left/right pair on the parallel side.

Top module: `slave_audio_port`

## Requirements
- R1: While reset is active and right after it is released, `rx_left`, `rx_right`, `frame_valid` and `ser_dout` are all zero.
- R2: With `fmt` = 0 (I2S), the MSB of a channel word is in the second slot after a `lr_sel` change. The LSB of a word that fills the whole channel falls in the first slot of the next `lr_sel` level. `lr_sel` low selects the left channel and high selects the right channel.
- R3: With `fmt` = 1 (MSB-justified), the MSB of a channel word is in the first slot after a `lr_sel` change, and the remaining bits follow MSB first.
- R4: With `fmt` = 2 (LSB-justified), the LSB of a channel word is in the last slot before the next `lr_sel` change.
- R5: `wlen` = 0, 1, 2 and 3 select 16, 18, 20 and 24 bit words. Received words are right-aligned in the 24-bit outputs, and every bit above the width reads zero. Serial bits that fall outside the word are ignored.
- R6: `ser_dout` carries `tx_left` and `tx_right` in the selected format and width. It changes only while the bit clock is low. It is zero in every slot that holds no word bit.
- R7: `frame_valid` is a single system-clock pulse raised after a right-channel word is captured. `rx_left` and `rx_right` change only in that cycle. The first pulse after reset comes only once a complete left and a complete right word have been captured.
- R8: Channels of up to 64 slots (128 bit clocks per frame) are handled in every format, including LSB-justified with a short word.
- R9: `fmt` = 3 behaves exactly as I2S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, locked to the serial timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2 LSB-justified, 3 I2S |
| wlen | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 bits |
| ser_clk | input | 1 | Bit clock from the external master |
| lr_sel | input | 1 | Channel select from the master, low = left |
| ser_din | input | 1 | Serial data into the port |
| tx_left | input | 24 | Left word to transmit, right-aligned |
| tx_right | input | 24 | Right word to transmit, right-aligned |
| ser_dout | output | 1 | Serial data out of the port |
| rx_left | output | 24 | Last received left word, right-aligned |
| rx_right | output | 24 | Last received right word, right-aligned |
| frame_valid | output | 1 | One-cycle strobe marking a new received pair |

## Verification
The receive path produces a word pair once per frame. A wrong slot counter or a misplaced boundary on that path shows up as a shifted or truncated word at the next `frame_valid`, which is at most one frame later. A missing or extra strobe shows up as a wrong pulse count over a run of frames. On the transmit path, a wrong slot index or channel choice corrupts `ser_dout` within the slot where it occurs. For that reason the bench compares every output slot from the third frame onward against a model of the framing. A wrong measured channel length in LSB-justified mode shows up as a shifted word from the second channel after reset.

// File: rtl/slave_audio_port.sv
module slave_audio_port #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_SLOTS   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wlen,
  input  logic        ser_clk,
  input  logic        lr_sel,
  input  logic        ser_din,
  input  logic [23:0] tx_left,
  input  logic [23:0] tx_right,
  output logic        ser_dout,
  output logic [23:0] rx_left,
  output logic [23:0] rx_right,
  output logic        frame_valid
);
  localparam int DW = 24;
  localparam int AW = $clog2(DW);
  localparam int CW = $clog2(MAX_SLOTS + 1);
  localparam int IW = CW + 2;

  // synchronizers of equal depth keep select and data aligned to the bit clock
  logic [SYNC_STAGES-1:0] clk_sr, lr_sr, din_sr;
  logic sclk_s, lr_s, din_s, sclk_q, fall_d;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sr <= '0;
      lr_sr  <= '0;
      din_sr <= '0;
      sclk_q <= 1'b0;
      fall_d <= 1'b0;
    end else begin
      clk_sr <= {clk_sr[SYNC_STAGES-2:0], ser_clk};
      lr_sr  <= {lr_sr[SYNC_STAGES-2:0], lr_sel};
      din_sr <= {din_sr[SYNC_STAGES-2:0], ser_din};
      sclk_q <= sclk_s;
      fall_d <= fall;
    end
  end

  assign sclk_s = clk_sr[SYNC_STAGES-1];
  assign lr_s   = lr_sr[SYNC_STAGES-1];
  assign din_s  = din_sr[SYNC_STAGES-1];
  assign rise   = sclk_s & ~sclk_q;
  assign fall   = ~sclk_s & sclk_q;

  logic fmt_i2s, fmt_lsb;
  assign fmt_i2s = (fmt == 2'd0) || (fmt == 2'd3);
  assign fmt_lsb = (fmt == 2'd2);

  logic [CW-1:0] wl_n;
  always_comb begin
    case (wlen)
      2'd0:    wl_n = CW'(16);
      2'd1:    wl_n = CW'(18);
      2'd2:    wl_n = CW'(20);
      default: wl_n = CW'(24);
    endcase
  end

  logic [DW:0]   one_sh;
  logic [DW-1:0] wmask;
  assign one_sh = (DW+1)'(1) << wl_n;
  assign wmask  = one_sh[DW-1:0] - DW'(1);

  // ---------------- receive ----------------
  logic          ws_a, ws_b, locked, left_ok;
  logic [1:0]    rx_prim;
  logic [CW-1:0] rx_cnt;
  logic [DW-1:0] rx_sr, hold_left, rx_word;
  logic          rx_chan, rx_pchan, rx_bnd;

  // I2S runs one slot behind the select line, so its channel view is the delayed one
  assign rx_chan  = fmt_i2s ? ws_a : lr_s;
  assign rx_pchan = fmt_i2s ? ws_b : ws_a;
  assign rx_bnd   = (rx_prim == 2'd2) && (rx_chan != rx_pchan);
  assign rx_word  = rx_sr & wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_a        <= 1'b0;
      ws_b        <= 1'b0;
      rx_prim     <= 2'd0;
      locked      <= 1'b0;
      left_ok     <= 1'b0;
      rx_cnt      <= '0;
      rx_sr       <= '0;
      hold_left   <= '0;
      rx_left     <= '0;
      rx_right    <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (rise) begin
        ws_a <= lr_s;
        ws_b <= ws_a;
        if (rx_prim != 2'd2) rx_prim <= rx_prim + 2'd1;
        if (rx_bnd) begin
          if (locked) begin
            if (!rx_pchan) begin
              hold_left <= rx_word;
              left_ok   <= 1'b1;
            end else if (left_ok) begin
              rx_left     <= hold_left;
              rx_right    <= rx_word;
              frame_valid <= 1'b1;
            end
          end
          locked <= 1'b1;
          rx_sr  <= {{(DW-1){1'b0}}, din_s};
          rx_cnt <= CW'(1);
        end else if (fmt_lsb || (rx_cnt < wl_n)) begin
          rx_sr <= {rx_sr[DW-2:0], din_s};
          if (rx_cnt != '1) rx_cnt <= rx_cnt + CW'(1);
        end
      end
    end
  end

  // ---------------- transmit ----------------
  logic          wsf_q, wsf_qq, tseen, n_ok;
  logic [1:0]    tx_prim;
  logic [CW-1:0] t_q, n_q, t_n, n_n;
  logic [DW-1:0] word_q, word_n;
  logic          tx_chan, tx_pchan, tx_chg, nok_n, bit_n;
  logic signed [IW-1:0] idx;

  always_comb begin
    tx_chan  = fmt_i2s ? wsf_q  : lr_s;
    tx_pchan = fmt_i2s ? wsf_qq : wsf_q;
    tx_chg   = (tx_prim == 2'd2) && (tx_chan != tx_pchan);
    t_n      = tx_chg ? '0 : ((t_q != '1) ? t_q + CW'(1) : t_q);
    n_n      = tx_chg ? t_q + CW'(1) : n_q;
    nok_n    = tx_chg ? tseen : n_ok;
    word_n   = tx_chg ? ((tx_chan ? tx_right : tx_left) & wmask) : word_q;
    idx      = fmt_lsb ? ($signed({2'b00, n_n}) - $signed({2'b00, t_n}) - IW'(1))
                       : ($signed({2'b00, wl_n}) - $signed({2'b00, t_n}) - IW'(1));
    bit_n    = !idx[IW-1] && (idx < $signed({2'b00, wl_n})) &&
               (!fmt_lsb || nok_n) && word_n[idx[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsf_q    <= 1'b0;
      wsf_qq   <= 1'b0;
      tx_prim  <= 2'd0;
      tseen    <= 1'b0;
      n_ok     <= 1'b0;
      t_q      <= '0;
      n_q      <= '0;
      word_q   <= '0;
      ser_dout <= 1'b0;
    end else if (fall_d) begin
      wsf_q  <= lr_s;
      wsf_qq <= wsf_q;
      if (tx_prim != 2'd2) tx_prim <= tx_prim + 2'd1;
      if (tx_chg) tseen <= 1'b1;
      t_q      <= t_n;
      n_q      <= n_n;
      n_ok     <= nok_n;
      word_q   <= word_n;
      ser_dout <= bit_n;
    end
  end

  AST_FV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R7
  AST_FV_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(rise)); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(rx_left) && $stable(rx_right))); // R7
  AST_RX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_left | rx_right) & ~wmask) == '0); // R5
  AST_TX_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> !sclk_s); // R6
endmodule

// File: tb/slave_audio_port_tb.sv
module slave_audio_port_tb_top;
  localparam int H = 6;
  localparam int F = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt = 2'd0, wlen = 2'd3;
  logic ser_clk = 1'b1, lr_sel = 1'b0, ser_din = 1'b0;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic ser_dout, frame_valid;
  logic [23:0] rx_left, rx_right;

  always #2 clk = ~clk;

  slave_audio_port dut_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .wlen(wlen),
    .ser_clk(ser_clk), .lr_sel(lr_sel), .ser_din(ser_din),
    .tx_left(tx_left), .tx_right(tx_right), .ser_dout(ser_dout),
    .rx_left(rx_left), .rx_right(rx_right), .frame_valid(frame_valid)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int cfg_fm, cfg_w, cfg_s;
  bit cfg_pad;
  logic [23:0] wl_arr [0:7];
  logic [23:0] wr_arr [0:7];
  logic [23:0] rcv_l [0:15];
  logic [23:0] rcv_r [0:15];
  int rcv_n = 0;
  bit obits [0:1023];

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      if (rcv_n < 16) begin
        rcv_l[rcv_n] = rx_left;
        rcv_r[rcv_n] = rx_right;
      end
      rcv_n = rcv_n + 1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit slot_bit(int g, bit use_tx);
    int gg, k, pos, t, idx;
    bit ch;
    logic [23:0] w;
    gg = (cfg_fm == 0) ? g - 1 : g;
    if (gg < 0) return use_tx ? 1'b0 : cfg_pad;
    k   = gg / (2 * cfg_s);
    pos = gg % (2 * cfg_s);
    ch  = (pos >= cfg_s);
    t   = pos % cfg_s;
    idx = (cfg_fm == 2) ? cfg_s - 1 - t : cfg_w - 1 - t;
    if (use_tx) w = ch ? tx_right : tx_left;
    else        w = ch ? wr_arr[k] : wl_arr[k];
    if (idx >= 0 && idx < cfg_w) return w[idx];
    return use_tx ? 1'b0 : cfg_pad;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    ser_clk = 1'b1; lr_sel = 1'b0; ser_din = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(rx_left == 24'h0, "R1 rx_left after reset", 32'(rx_left), 0);
    chk(rx_right == 24'h0, "R1 rx_right after reset", 32'(rx_right), 0);
    chk(frame_valid == 1'b0, "R1 frame_valid after reset", 32'(frame_valid), 0);
    chk(ser_dout == 1'b0, "R1 ser_dout after reset", 32'(ser_dout), 0);
  endtask

  task automatic scenario(string req, int code, int fm, int wcode, int w, int s, bit pad);
    logic [23:0] m;
    int bad, first_g;
    bit exp_b;
    cfg_fm = fm; cfg_w = w; cfg_s = s; cfg_pad = pad;
    fmt = 2'(code); wlen = 2'(wcode);
    tx_left  = 24'hC3A55A ^ 24'(s);
    tx_right = 24'h5AF00F ^ 24'(w * 3);
    for (int k = 0; k < 8; k++) begin
      wl_arr[k] = 24'h9A3C5F ^ (24'(k) * 24'h0F1E37);
      wr_arr[k] = 24'h36C9A1 + (24'(k) * 24'h010321);
    end
    m = (w == 24) ? 24'hFFFFFF : 24'((32'h1 << w) - 1);
    do_reset();
    rcv_n = 0;
    for (int g = 0; g < F * 2 * s; g++) begin
      ser_clk = 1'b0;
      lr_sel  = ((g % (2 * s)) >= s);
      ser_din = slot_bit(g, 1'b0);
      repeat (H) @(negedge clk);
      obits[g] = ser_dout;
      ser_clk = 1'b1;
      repeat (H) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(rcv_n == F - 2, {req, " R7 strobe count"}, 32'(rcv_n), 32'(F - 2));
    for (int i = 0; i < F - 2; i++) begin
      if (i < rcv_n) begin
        chk(rcv_l[i] == (wl_arr[i+1] & m), {req, " left word"}, 32'(rcv_l[i]), 32'(wl_arr[i+1] & m));
        chk(rcv_r[i] == (wr_arr[i+1] & m), {req, " right word"}, 32'(rcv_r[i]), 32'(wr_arr[i+1] & m));
      end
    end
    bad = 0; first_g = -1;
    for (int g = 4 * s; g < F * 2 * s; g++) begin
      exp_b = slot_bit(g, 1'b1);
      if (obits[g] != exp_b) begin
        bad++;
        if (first_g < 0) first_g = g;
      end
    end
    chk(bad == 0, {req, " R6 transmit slots"}, 32'(first_g), 32'hFFFFFFFF);
  endtask

  task automatic t_i2s_24();    scenario("R2 R5 i2s w24",      0, 0, 3, 24, 32, 1'b1); endtask
  task automatic t_msb_16();    scenario("R3 R5 msb w16",      1, 1, 0, 16, 32, 1'b1); endtask
  task automatic t_lsb_20();    scenario("R4 R5 lsb w20",      2, 2, 2, 20, 32, 1'b1); endtask
  task automatic t_lsb_18_64(); scenario("R8 R4 lsb w18 s64",  2, 2, 1, 18, 64, 1'b1); endtask
  task automatic t_i2s_full();  scenario("R2 i2s w16 s16",     0, 0, 0, 16, 16, 1'b0); endtask
  task automatic t_msb_full();  scenario("R3 R8 msb w24 s64",  1, 1, 3, 24, 64, 1'b0); endtask
  task automatic t_code3();     scenario("R9 code3 w20",       3, 0, 2, 20, 24, 1'b1); endtask

  initial begin
    t_reset_state();
    t_i2s_24();
    t_msb_16();
    t_lsb_20();
    t_lsb_18_64();
    t_i2s_full();
    t_msb_full();
    t_code3();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule